// File: doc/BRIEF.md
# DDR Fast-Cycle DRAM Command Sequencer

This block sits on the controller side of a four-bank, double-data-rate, fast-cycle synchronous DRAM. It takes read and write requests on a valid/ready port. Each request carries a 2-bit bank, an upper address and a lower address. Every access goes out as a two-clock command on a registered chip-select / function / bank / address bus. The block then times the write data and the read capture from a programmable CAS latency and burst length. The data bus is modelled as two words per clock, one word for each clock edge.

A controller first loads the latency and burst configuration. It then streams requests. Between requests the sequencer keeps the random-cycle spacing. It also inserts a distributed auto-refresh each time its interval counter expires. The control path is a four-state machine:
- UNCFG: after reset. The block leaves it when a legal configuration is held.
- IDLE: a pending refresh goes to CMD2. Otherwise an accepted request goes to CMD2.
- CMD2: the second command clock. It always goes to WAIT.
- WAIT: counts down the spacing for the command just issued, then goes back to IDLE.

Top module: `ddrseq_top`

## Requirements
- R1: A `cfg_load` pulse with `cfg_cas` of 4, 5 or 6 stores that CAS latency. In the same pulse, `cfg_bl4` selects the burst: 1 for four words, 0 for two words. A load with any other CAS value changes nothing, and the earlier setting stays in use.
- R2: From reset until a legal configuration has been loaded, `cmd_cs_n` stays 1 and `req_ready` stays 0. The first request can be accepted in the second cycle after the loading cycle.
- R3: Each command spans two clocks.
  - Access, first clock: `cs_n`=0, `fn`=1 for a read or 0 for a write, `ba`=bank, `addr`=upper address.
  - Access, second clock: `cs_n`=1, `fn`=0, `ba`=bank, `addr`=lower address, zero-extended.
  - Refresh: first clock is `cs_n`=0, `fn`=0, with `ba` and `addr` at 0. Second clock is `cs_n`=1, `fn`=1, with `ba` and `addr` at 0.
  - Idle bus: `cs_n`=1, `fn`=0, with `ba` and `addr` at 0.
- R4: Write latency is CL−1 clocks after the second command clock. With the first command clock in cycle T, `wr_data_req` is high in cycles T+CL−1 through T+CL−2+BL/2. `dq_oe` is high in cycles T+CL through T+CL−1+BL/2. In each of those cycles, `dq_out0`/`dq_out1` carry the words presented on `wr_data0`/`wr_data1` in the cycle before.
- R5: Reads capture `dq_in0`/`dq_in1` in cycles T+CL+1 through T+CL+BL/2. Each captured pair appears on `rd_data0`/`rd_data1` one cycle later, with `rd_valid` high.
- R6: Every read return carries `rd_tag`. The tag is the read's position in issue order, counted from 0 and wrapping at 2^TAG_W.
- R7: The first clock of an access command comes no earlier than max(TRC_CLKS, CL+1+BL/2) cycles after the first clock of the previous access command. After a refresh command, the spacing is TRC_CLKS. A waiting request is issued exactly at that bound.
- R8: A refresh becomes pending every REFI_CLKS cycles. The count runs from the end of reset.
- R9: `req_ready` is high only in IDLE with no refresh pending. A pending refresh is issued before any waiting request.
- R10: A request is taken when `req_valid` and `req_ready` are both high at a clock edge. Its first command clock drives the bus in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load configuration pulse |
| cfg_cas | input | 3 | Requested CAS latency |
| cfg_bl4 | input | 1 | 1 = burst of four words, 0 = two |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank select |
| req_ua | input | UA_W | Upper address |
| req_la | input | LA_W | Lower address |
| wr_data_req | output | 1 | Present write words on the next edge |
| wr_data0 | input | DW | Write word, first edge |
| wr_data1 | input | DW | Write word, second edge |
| cmd_cs_n | output | 1 | Command chip select, low active |
| cmd_fn | output | 1 | Command function bit |
| cmd_ba | output | 2 | Command bank |
| cmd_addr | output | max(UA_W,LA_W) | Command address |
| dq_out0 | output | DW | Bus word, first edge |
| dq_out1 | output | DW | Bus word, second edge |
| dq_oe | output | 1 | Bus drive enable |
| dq_in0 | input | DW | Captured word, first edge |
| dq_in1 | input | DW | Captured word, second edge |
| rd_valid | output | 1 | Read pair valid |
| rd_data0 | output | DW | Read word, first edge |
| rd_data1 | output | DW | Read word, second edge |
| rd_tag | output | TAG_W | In-order read tag |

## Verification
The bench builds the block with TRC_CLKS=8 and REFI_CLKS=60. A short refresh interval means several refreshes fall inside a few hundred cycles, and some of them land while requests are queued. The random-cycle bound of 8 exceeds the burst span at CL 4 with BL 2. At CL 6 with BL 4 the burst span of 9 wins instead, so both arms of the R7 spacing rule are exercised. Every legal CAS value and both burst lengths are loaded. One rejected load arrives before the first legal load, and another arrives later against a live setting.

// File: rtl/ddrseq_pkg.sv
package ddrseq_pkg;

    typedef enum logic [1:0] {
        ST_UNCFG = 2'd0,
        ST_IDLE  = 2'd1,
        ST_CMD2  = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_READ    = 2'd1,
        OP_WRITE   = 2'd2,
        OP_REFRESH = 2'd3
    } seq_op_t;

    localparam int CAS_MIN = 4;
    localparam int CAS_MAX = 6;
    localparam int CAS_W   = 3;

endpackage

// File: rtl/ddrseq_cfg.sv
module ddrseq_cfg
    import ddrseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CAS_W-1:0] cas_in,
    input  logic             bl4_in,
    output logic [CAS_W-1:0] cas,
    output logic             bl4,
    output logic             valid
);

    logic legal;
    assign legal = (int'(cas_in) >= CAS_MIN) && (int'(cas_in) <= CAS_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas   <= CAS_W'(CAS_MIN);
            bl4   <= 1'b0;
            valid <= 1'b0;
        end else if (load && legal) begin
            cas   <= cas_in;
            bl4   <= bl4_in;
            valid <= 1'b1;
        end
    end

    // R1: a held setting is always a legal latency
    a_r1_cas_legal: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (int'(cas) >= CAS_MIN && int'(cas) <= CAS_MAX));

    // R1: an illegal load leaves the setting untouched
    a_r1_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !legal) |=> ($stable(cas) && $stable(bl4)));

endmodule

// File: rtl/ddrseq_refresh.sv
module ddrseq_refresh #(
    parameter int REFI_CLKS = 1300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    output logic pending
);

    localparam int CNT_W = $clog2(REFI_CLKS);

    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick = (cnt_q == CNT_W'(REFI_CLKS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pending <= 1'b0;
        end else begin
            cnt_q   <= tick ? '0 : cnt_q + 1'b1;
            pending <= tick | (pending & ~issue);
        end
    end

    // R8: a pending refresh is only dropped by issuing it
    a_r8_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !issue) |=> pending);

endmodule

// File: rtl/ddrseq_datapath.sv
module ddrseq_datapath
    import ddrseq_pkg::*;
#(
    parameter int DW    = 18,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_wr,
    input  logic [CAS_W-1:0] start_cas,
    input  logic             start_bl4,
    output logic             wr_data_req,
    input  logic [DW-1:0]    wr_data0,
    input  logic [DW-1:0]    wr_data1,
    output logic [DW-1:0]    dq_out0,
    output logic [DW-1:0]    dq_out1,
    output logic             dq_oe,
    input  logic [DW-1:0]    dq_in0,
    input  logic [DW-1:0]    dq_in1,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data0,
    output logic [DW-1:0]    rd_data1,
    output logic [TAG_W-1:0] rd_tag
);

    localparam int PH_W = 4;

    logic             active_q;
    logic             is_wr_q;
    logic [PH_W-1:0]  ph_q;
    logic [PH_W-1:0]  cas_q;
    logic [PH_W-1:0]  half_q;
    logic [TAG_W-1:0] next_tag_q;
    logic [TAG_W-1:0] cur_tag_q;
    logic             wr_win;
    logic             rd_win;
    logic             last_ph;

    assign wr_win  = active_q && is_wr_q &&
                     (ph_q >= cas_q - PH_W'(1)) &&
                     (ph_q <  cas_q - PH_W'(1) + half_q);
    assign rd_win  = active_q && !is_wr_q &&
                     (ph_q >= cas_q + PH_W'(1)) &&
                     (ph_q <= cas_q + half_q);
    assign last_ph = (ph_q == cas_q + half_q);
    assign wr_data_req = wr_win;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            is_wr_q    <= 1'b0;
            ph_q       <= '0;
            cas_q      <= PH_W'(CAS_MIN);
            half_q     <= PH_W'(1);
            next_tag_q <= '0;
            cur_tag_q  <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            is_wr_q  <= start_wr;
            ph_q     <= '0;
            cas_q    <= PH_W'(start_cas);
            half_q   <= start_bl4 ? PH_W'(2) : PH_W'(1);
            if (!start_wr) begin
                cur_tag_q  <= next_tag_q;
                next_tag_q <= next_tag_q + 1'b1;
            end
        end else if (active_q) begin
            ph_q <= ph_q + 1'b1;
            if (last_ph) begin
                active_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe    <= 1'b0;
            dq_out0  <= '0;
            dq_out1  <= '0;
            rd_valid <= 1'b0;
            rd_data0 <= '0;
            rd_data1 <= '0;
            rd_tag   <= '0;
        end else begin
            dq_oe    <= wr_win;
            if (wr_win) begin
                dq_out0 <= wr_data0;
                dq_out1 <= wr_data1;
            end
            rd_valid <= rd_win;
            if (rd_win) begin
                rd_data0 <= dq_in0;
                rd_data1 <= dq_in1;
            end
            rd_tag   <= cur_tag_q;
        end
    end

    // R4: the bus is only driven right after a data request
    a_r4_oe_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(wr_data_req));

    // R5: a write burst never overlaps a read return
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_data_req && rd_valid));

endmodule

// File: rtl/ddrseq_top.sv
module ddrseq_top
    import ddrseq_pkg::*;
#(
    parameter int DW        = 18,
    parameter int UA_W      = 12,
    parameter int LA_W      = 10,
    parameter int TAG_W     = 4,
    parameter int TRC_CLKS  = 7,
    parameter int REFI_CLKS = 1300
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic [2:0]          cfg_cas,
    input  logic                cfg_bl4,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [1:0]          req_bank,
    input  logic [UA_W-1:0]     req_ua,
    input  logic [LA_W-1:0]     req_la,
    output logic                wr_data_req,
    input  logic [DW-1:0]       wr_data0,
    input  logic [DW-1:0]       wr_data1,
    output logic                cmd_cs_n,
    output logic                cmd_fn,
    output logic [1:0]          cmd_ba,
    output logic [((UA_W > LA_W) ? UA_W : LA_W)-1:0] cmd_addr,
    output logic [DW-1:0]       dq_out0,
    output logic [DW-1:0]       dq_out1,
    output logic                dq_oe,
    input  logic [DW-1:0]       dq_in0,
    input  logic [DW-1:0]       dq_in1,
    output logic                rd_valid,
    output logic [DW-1:0]       rd_data0,
    output logic [DW-1:0]       rd_data1,
    output logic [TAG_W-1:0]    rd_tag
);

    localparam int AW      = (UA_W > LA_W) ? UA_W : LA_W;
    localparam int LONGEST = (TRC_CLKS > CAS_MAX + 3) ? TRC_CLKS : CAS_MAX + 3;
    localparam int WC_W    = $clog2(LONGEST + 1);
    localparam logic [WC_W-1:0] TRC_V   = WC_W'(TRC_CLKS);
    localparam logic [WC_W-1:0] REF_GAP = WC_W'(TRC_CLKS - 3);

    logic [CAS_W-1:0] cas_q;
    logic             bl4_q;
    logic             cfg_valid;
    logic             ref_pend;
    logic             ref_issue;
    logic             accept;

    seq_state_t       state_q, state_d;
    seq_op_t          op_q;
    logic [1:0]       bank_q;
    logic [LA_W-1:0]  la_q;
    logic [WC_W-1:0]  gap_q;
    logic [WC_W-1:0]  wait_q;
    logic [WC_W-1:0]  burst_span;
    logic [WC_W-1:0]  acc_gap;

    ddrseq_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_load),
        .cas_in (cfg_cas),
        .bl4_in (cfg_bl4),
        .cas    (cas_q),
        .bl4    (bl4_q),
        .valid  (cfg_valid)
    );

    ddrseq_refresh #(.REFI_CLKS(REFI_CLKS)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (ref_issue),
        .pending (ref_pend)
    );

    assign req_ready = (state_q == ST_IDLE) && !ref_pend;
    assign ref_issue = (state_q == ST_IDLE) && ref_pend;
    assign accept    = req_ready && req_valid;

    assign burst_span = WC_W'(cas_q) + WC_W'(1) + (bl4_q ? WC_W'(2) : WC_W'(1));
    assign acc_gap    = ((burst_span < TRC_V) ? TRC_V : burst_span) - WC_W'(3);

    ddrseq_datapath #(.DW(DW), .TAG_W(TAG_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_wr    (req_write),
        .start_cas   (cas_q),
        .start_bl4   (bl4_q),
        .wr_data_req (wr_data_req),
        .wr_data0    (wr_data0),
        .wr_data1    (wr_data1),
        .dq_out0     (dq_out0),
        .dq_out1     (dq_out1),
        .dq_oe       (dq_oe),
        .dq_in0      (dq_in0),
        .dq_in1      (dq_in1),
        .rd_valid    (rd_valid),
        .rd_data0    (rd_data0),
        .rd_data1    (rd_data1),
        .rd_tag      (rd_tag)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNCFG: if (cfg_valid)             state_d = ST_IDLE;
            ST_IDLE:  if (ref_pend || req_valid) state_d = ST_CMD2;
            ST_CMD2:                             state_d = ST_WAIT;
            ST_WAIT:  if (wait_q == '0)          state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_UNCFG;
        else        state_q <= state_d;
    end

    // command context and spacing counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            bank_q <= '0;
            la_q   <= '0;
            gap_q  <= '0;
            wait_q <= '0;
        end else begin
            if (ref_issue) begin
                op_q  <= OP_REFRESH;
                gap_q <= REF_GAP;
            end else if (accept) begin
                op_q   <= req_write ? OP_WRITE : OP_READ;
                bank_q <= req_bank;
                la_q   <= req_la;
                gap_q  <= acc_gap;
            end
            if (state_q == ST_CMD2) begin
                wait_q <= gap_q;
            end else if (state_q == ST_WAIT && wait_q != '0) begin
                wait_q <= wait_q - 1'b1;
            end
        end
    end

    // registered command bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_cs_n <= 1'b1;
            cmd_fn   <= 1'b0;
            cmd_ba   <= '0;
            cmd_addr <= '0;
        end else begin
            cmd_cs_n <= 1'b1;
            cmd_fn   <= 1'b0;
            cmd_ba   <= '0;
            cmd_addr <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (ref_issue) begin
                        cmd_cs_n <= 1'b0;
                    end else if (accept) begin
                        cmd_cs_n <= 1'b0;
                        cmd_fn   <= ~req_write;
                        cmd_ba   <= req_bank;
                        cmd_addr <= AW'(req_ua);
                    end
                end
                ST_CMD2: begin
                    if (op_q == OP_REFRESH) begin
                        cmd_fn <= 1'b1;
                    end else begin
                        cmd_ba   <= bank_q;
                        cmd_addr <= AW'(la_q);
                    end
                end
                ST_UNCFG, ST_WAIT: ;
            endcase
        end
    end

    // spacing monitor for the assertion
    logic [WC_W:0] since_q;
    logic          seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else begin
            if (!cmd_cs_n) begin
                since_q <= (WC_W+1)'(1);
                seen_q  <= 1'b1;
            end else if (since_q != {(WC_W+1){1'b1}}) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    // R3: a first command clock is followed by a non-select clock
    a_r3_cmd_two_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_cs_n |=> cmd_cs_n);

    // R2: nothing is issued without a legal configuration
    a_r2_quiet_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> cmd_cs_n);

    // R7: commands never come closer than the random cycle
    a_r7_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_cs_n && seen_q) |-> (since_q >= (WC_W+1)'(TRC_CLKS)));

    // R9: an idle machine with refresh pending issues the refresh next
    a_r9_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pend && state_q == ST_IDLE) |=> (!cmd_cs_n && !cmd_fn && cmd_addr == '0));

    // R10: an accepted request drives its first command clock next
    a_r10_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!cmd_cs_n && cmd_fn == !$past(req_write)));

endmodule

// File: tb/ddrseq_top_tb_top.sv
module ddrseq_top_tb_top;

    localparam int DW    = 18;
    localparam int UA_W  = 12;
    localparam int LA_W  = 10;
    localparam int TAG_W = 4;
    localparam int TRC   = 8;
    localparam int REFI  = 60;
    localparam int AW    = 12;
    localparam int CW    = AW + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0;
    logic [2:0] cfg_cas = 3'd0;
    logic cfg_bl4 = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [1:0] req_bank = 2'd0;
    logic [UA_W-1:0] req_ua = '0;
    logic [LA_W-1:0] req_la = '0;
    logic wr_data_req;
    logic [DW-1:0] wr_data0 = '0, wr_data1 = '0;
    logic cmd_cs_n, cmd_fn;
    logic [1:0] cmd_ba;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] dq_out0, dq_out1;
    logic dq_oe;
    logic [DW-1:0] dq_in0 = '0, dq_in1 = '0;
    logic rd_valid;
    logic [DW-1:0] rd_data0, rd_data1;
    logic [TAG_W-1:0] rd_tag;

    ddrseq_top #(.DW(DW), .UA_W(UA_W), .LA_W(LA_W), .TAG_W(TAG_W),
                 .TRC_CLKS(TRC), .REFI_CLKS(REFI)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_cas(cfg_cas),
        .cfg_bl4(cfg_bl4), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_ua(req_ua),
        .req_la(req_la), .wr_data_req(wr_data_req), .wr_data0(wr_data0),
        .wr_data1(wr_data1), .cmd_cs_n(cmd_cs_n), .cmd_fn(cmd_fn),
        .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .dq_out0(dq_out0),
        .dq_out1(dq_out1), .dq_oe(dq_oe), .dq_in0(dq_in0), .dq_in1(dq_in1),
        .rd_valid(rd_valid), .rd_data0(rd_data0), .rd_data1(rd_data1),
        .rd_tag(rd_tag)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = -1;
    bit done = 1'b0;

    function automatic logic [DW-1:0] fw0(int m); return DW'(m * 3 + 1);  endfunction
    function automatic logic [DW-1:0] fw1(int m); return DW'(m * 5 + 2);  endfunction
    function automatic logic [DW-1:0] fr0(int m); return DW'(m * 7 + 3);  endfunction
    function automatic logic [DW-1:0] fr1(int m); return DW'(m * 11 + 4); endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // data inputs follow the cycle number
    always @(posedge clk) begin
        #1;
        wr_data0 = fw0(cyc);
        wr_data1 = fw1(cyc);
        dq_in0   = fr0(cyc);
        dq_in1   = fr1(cyc);
    end

    // reference model state
    logic [CW-1:0] e_cmd [int];
    bit e_wreq [int];
    bit e_oe [int];
    bit e_rdv [int];
    int e_tag [int];
    int e_min [int];
    int m_on_at = 1 << 30;
    int m_free = 0;
    int m_cl = 4;
    bit m_bl4 = 1'b0;
    bit m_pend = 1'b0;
    int m_tag = 0;
    int m_refs = 0;
    int obs_refs = 0;
    int last_cmd1 = -1;
    int last_min = 0;
    int wr_T = 0;
    int wr_cl = 0;
    bit prev_wreq = 1'b0;

    localparam logic [CW-1:0] IDLE_CMD = {1'b1, 1'b0, 2'b00, {AW{1'b0}}};

    always @(negedge clk) begin
        if (!rst_n) begin
            if (cyc < 0 && !done && $time > 15) begin
                chk(cmd_cs_n == 1'b1 && req_ready == 1'b0 && !rd_valid && !dq_oe,
                    "R2 reset state", {cmd_cs_n, req_ready, rd_valid, dq_oe}, 4'b1000);
            end
        end else if (cyc >= 0 && !done) begin
            int n;
            bit idle, exp_ready, ewr, eoe, erv;
            logic [CW-1:0] ecmd;
            n = cyc;
            idle = (n >= m_on_at) && (n >= m_free);
            exp_ready = idle && !m_pend;
            chk(req_ready == exp_ready, "R9 ready", req_ready, exp_ready);
            ecmd = e_cmd.exists(n) ? e_cmd[n] : IDLE_CMD;
            chk({cmd_cs_n, cmd_fn, cmd_ba, cmd_addr} == ecmd, "R3 R10 command",
                {cmd_cs_n, cmd_fn, cmd_ba, cmd_addr}, ecmd);
            if (n < m_on_at) chk(cmd_cs_n == 1'b1, "R2 quiet", cmd_cs_n, 1);
            ewr = e_wreq.exists(n);
            chk(wr_data_req == ewr, "R4 write request", wr_data_req, ewr);
            eoe = e_oe.exists(n);
            chk(dq_oe == eoe, "R4 drive enable", dq_oe, eoe);
            if (eoe) begin
                chk(dq_out0 == fw0(n - 1), "R4 word0", dq_out0, fw0(n - 1));
                chk(dq_out1 == fw1(n - 1), "R4 word1", dq_out1, fw1(n - 1));
            end
            erv = e_rdv.exists(n);
            chk(rd_valid == erv, "R5 read valid", rd_valid, erv);
            if (erv) begin
                chk(rd_data0 == fr0(n - 1), "R5 word0", rd_data0, fr0(n - 1));
                chk(rd_data1 == fr1(n - 1), "R5 word1", rd_data1, fr1(n - 1));
                chk(int'(rd_tag) == e_tag[n], "R6 tag", rd_tag, e_tag[n]);
            end
            if (!cmd_cs_n) begin
                if (last_cmd1 >= 0) chk(n - last_cmd1 >= last_min, "R7 spacing", n - last_cmd1, last_min);
                last_cmd1 = n;
                last_min = e_min.exists(n) ? e_min[n] : TRC;
            end
            if (cmd_cs_n && cmd_fn) obs_refs++;
            if (wr_data_req && !prev_wreq)
                chk(n - wr_T == wr_cl - 1, "R1 R4 write latency", n - wr_T, wr_cl - 1);
            prev_wreq = wr_data_req;

            // effects of the coming edge
            if (idle && m_pend) begin
                e_cmd[n + 1] = {1'b0, 1'b0, 2'b00, {AW{1'b0}}};
                e_cmd[n + 2] = {1'b1, 1'b1, 2'b00, {AW{1'b0}}};
                e_min[n + 1] = TRC;
                m_free = n + TRC;
                m_pend = 1'b0;
                m_refs++;
            end else if (exp_ready && req_valid) begin
                int T, h, gap;
                T = n + 1;
                h = m_bl4 ? 2 : 1;
                gap = (m_cl + 1 + h > TRC) ? m_cl + 1 + h : TRC;
                e_cmd[T]     = {1'b0, ~req_write, req_bank, AW'(req_ua)};
                e_cmd[T + 1] = {1'b1, 1'b0, req_bank, AW'(req_la)};
                e_min[T] = gap;
                m_free = n + gap;
                for (int k = 0; k < h; k++) begin
                    if (req_write) begin
                        e_wreq[T + m_cl - 1 + k] = 1'b1;
                        e_oe[T + m_cl + k] = 1'b1;
                    end else begin
                        e_rdv[T + m_cl + 2 + k] = 1'b1;
                        e_tag[T + m_cl + 2 + k] = m_tag;
                    end
                end
                if (req_write) begin
                    wr_T = T;
                    wr_cl = m_cl;
                end else begin
                    m_tag = (m_tag + 1) % (1 << TAG_W);
                end
            end
            if ((n + 2) % REFI == 0) m_pend = 1'b1;
            if (cfg_load && cfg_cas >= 3'd4 && cfg_cas <= 3'd6) begin
                m_cl = int'(cfg_cas);
                m_bl4 = cfg_bl4;
                if (m_on_at > n + 2) m_on_at = n + 2;
            end
        end
    end

    task automatic load_cfg(int cas, bit b4);
        @(posedge clk); #1;
        cfg_load = 1'b1; cfg_cas = 3'(cas); cfg_bl4 = b4;
        @(posedge clk); #1;
        cfg_load = 1'b0;
    endtask

    task automatic send(bit w, int bank, int ua, int la);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = w;
        req_bank = 2'(bank); req_ua = UA_W'(ua); req_la = LA_W'(la);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog expired: actual 0 expected 1");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // request waiting while unconfigured; illegal load first (R1, R2)
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b0; req_bank = 2'd2;
        req_ua = UA_W'(12'h5a1); req_la = LA_W'(10'h13);
        repeat (3) @(posedge clk);
        load_cfg(3, 1'b1);
        repeat (3) @(posedge clk);
        load_cfg(5, 1'b1);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
        // CL5 BL4 mix
        send(1'b1, 0, 12'h101, 10'h011);
        send(1'b0, 1, 12'h202, 10'h022);
        send(1'b1, 3, 12'hfff, 10'h3ff);
        // illegal load against a live setting (R1)
        load_cfg(7, 1'b0);
        send(1'b1, 2, 12'h333, 10'h033);
        send(1'b0, 2, 12'h334, 10'h034);
        // CL4 BL2: spacing bound set by TRC (R7)
        load_cfg(4, 1'b0);
        send(1'b0, 1, 12'h040, 10'h001);
        send(1'b1, 1, 12'h041, 10'h002);
        send(1'b0, 0, 12'h042, 10'h003);
        // CL6 BL4: spacing bound set by the burst (R7)
        load_cfg(6, 1'b1);
        send(1'b1, 3, 12'h600, 10'h100);
        send(1'b0, 3, 12'h601, 10'h101);
        send(1'b0, 2, 12'h602, 10'h102);
        // long stream across several refreshes, tags wrap (R6, R8)
        for (int i = 0; i < 24; i++) begin
            if (i == 12) load_cfg(5, 1'b0);
            send(i[0], i % 4, 12'h700 + i, 10'h200 + i);
        end
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(obs_refs == m_refs, "R8 refresh count", obs_refs, m_refs);
        chk(m_refs >= 3, "R8 refreshes seen", m_refs, 3);
        done = 1'b1;
        finish_run();
    end

endmodule